// File: doc/BRIEF.md
# Byte Lane Steering Unit

This block sits between an 8-bit internal data path and a 16-bit external data bus. Every transfer carries exactly one byte. When the device sources a byte, either because a host reads it as a slave or because it is the DMA master writing to memory, the byte is driven on both halves of the bus. External address decoding and strobe logic can then store it at an even or an odd memory address.

When the device sinks a byte, the unit picks one bus half and registers the byte. It then presents the byte to the internal path with a one-cycle valid pulse. Slave writes always take the low half. DMA transfers into the device take the low half unless lane swapping is switched on. With swapping on, address bit A0 and a programmable polarity bit choose the half.

The two swap bits live in a small configuration register. A slave write with the configuration select asserted loads it, and a slave read with that select asserted reads it back. Strobe semantics are relative to the device: `src_stb` means the device drives a byte onto the bus, and `snk_stb` means the device takes a byte from the bus. Each strobe cycle is one transfer. If both strobes are high in the same cycle, the source strobe wins.

Top module: `byte_lane_steer`

## Requirements
- R1: After reset, `bus_oe` is 0, `bus_out` is 0, `in_valid` is 0 and both swap bits are 0.
- R2: A slave read (`src_stb`=1, `dma_act`=0, `cfg_sel`=0) asserts `bus_oe` in the same cycle and drives `bus_out` = {`out_byte`, `out_byte`}.
- R3: A slave data write (`snk_stb`=1, `dma_act`=0, `cfg_sel`=0) makes `in_byte` = `bus_in[7:0]` and `in_valid`=1 in the cycle after the strobe. `bus_in[15:8]` has no effect.
- R4: A DMA transfer to memory (`src_stb`=1, `dma_act`=1, `dma_dir`=1) asserts `bus_oe` and drives {`out_byte`, `out_byte`}.
- R5: A DMA transfer into the device (`snk_stb`=1, `dma_act`=1, `dma_dir`=0) with swapping disabled captures `bus_in[7:0]` for both A0 values.
- R6: With swapping enabled and select = 1, a DMA inbound transfer takes `bus_in[7:0]` when A0=0 and `bus_in[15:8]` when A0=1.
- R7: With swapping enabled and select = 0, a DMA inbound transfer takes `bus_in[15:8]` when A0=0 and `bus_in[7:0]` when A0=1.
- R8: A slave write with `cfg_sel`=1 loads swap enable from `bus_in[0]` and swap select from `bus_in[1]`. The new values govern transfers from the next clock edge on. A slave read with `cfg_sel`=1 returns {6'b0, select, enable} on both halves.
- R9: Outside a slave read or a DMA transfer to memory, `bus_oe` is 0 and `bus_out` is 0. This includes a source strobe while DMA runs toward the device.
- R10: The swap settings have no effect on slave data writes, which always take `bus_in[7:0]` whatever A0 is.
- R11: `in_valid` is high for exactly one cycle per inbound data transfer and stays 0 after a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_act | input | 1 | Device is bus master performing DMA |
| dma_dir | input | 1 | DMA direction: 1 device to memory, 0 memory to device |
| addr_a0 | input | 1 | Address bit A0 of the current transfer |
| src_stb | input | 1 | Device sources a byte this cycle |
| snk_stb | input | 1 | Device sinks a byte this cycle |
| cfg_sel | input | 1 | Slave access targets the configuration register |
| out_byte | input | 8 | Byte from the internal data path to send |
| bus_in | input | 16 | External data bus, inbound value |
| bus_out | output | 16 | External data bus, outbound value |
| bus_oe | output | 1 | Output enable for both bus halves |
| in_byte | output | 8 | Captured inbound byte |
| in_valid | output | 1 | One-cycle pulse marking a new `in_byte` |

## Verification
The hardest state to reach is a DMA inbound transfer that takes the high half. It only happens after a configuration write has turned swapping on, and it only shows as a difference when the two bus halves carry different bytes. The stimulus loads the configuration in one cycle and issues a DMA inbound transfer in the very next cycle, so the one-edge latency of the swap bits is tested. Every inbound transfer uses distinct bytes on the low and high halves. Each polarity is tried with both A0 values. A slave write is then issued with swapping still on, to show that the lane choice does not leak into slave mode.

// File: rtl/bls_pkg.sv
package bls_pkg;

   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_SOURCE   = 2'd1,
      PH_SLV_SINK = 2'd2,
      PH_DMA_SINK = 2'd3
   } bls_phase_e;

   typedef struct packed {
      logic swap_sel;
      logic swap_en;
   } bls_cfg_t;

   function automatic bls_phase_e bls_decode(input logic dma_act,
                                             input logic dma_dir,
                                             input logic src_stb,
                                             input logic snk_stb);
      bls_phase_e ph;
      ph = PH_IDLE;
      if (src_stb && (!dma_act || dma_dir))
         ph = PH_SOURCE;
      else if (snk_stb && !dma_act)
         ph = PH_SLV_SINK;
      else if (snk_stb && dma_act && !dma_dir)
         ph = PH_DMA_SINK;
      return ph;
   endfunction

endpackage

// File: rtl/bls_cfg_reg.sv
module bls_cfg_reg
   import bls_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int EN_BIT      = 0,
   parameter int SEL_BIT     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_byte,
   output bls_cfg_t          cfg,
   output logic [BYTE_W-1:0] rd_byte
);

   generate
      if (EN_BIT == SEL_BIT) begin : g_bad_bits
         $error("swap enable and select must use different bits");
      end
      if (EN_BIT >= BYTE_W || SEL_BIT >= BYTE_W) begin : g_bad_range
         $error("configuration bit outside the byte");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.swap_en  <= wr_byte[EN_BIT];
         cfg.swap_sel <= wr_byte[SEL_BIT];
      end
   end

   always_comb begin
      rd_byte          = '0;
      rd_byte[EN_BIT]  = cfg.swap_en;
      rd_byte[SEL_BIT] = cfg.swap_sel;
   end

   // R8: a configuration write lands on the next edge
   p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg.swap_en == $past(wr_byte[EN_BIT]))
             && (cfg.swap_sel == $past(wr_byte[SEL_BIT])));

   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg));

endmodule

// File: rtl/bls_lane_sel.sv
module bls_lane_sel #(
   parameter int BYTE_W   = 8,
   parameter bit HAS_SWAP = 1'b1
) (
   input  logic [2*BYTE_W-1:0] bus_word,
   input  logic                dma_sink,
   input  logic                swap_en,
   input  logic                swap_sel,
   input  logic                a0,
   output logic                take_high,
   output logic [BYTE_W-1:0]   lane_byte
);

   localparam int LO_MSB = BYTE_W - 1;
   localparam int HI_LSB = BYTE_W;

   generate
      if (HAS_SWAP) begin : g_swap
         // high half is chosen when the polarity bit equals A0
         assign take_high = dma_sink && swap_en && (swap_sel == a0);
      end else begin : g_fixed
         assign take_high = 1'b0;
      end
   endgenerate

   assign lane_byte = take_high ? bus_word[2*BYTE_W-1:HI_LSB]
                                : bus_word[LO_MSB:0];

   // R10: outside DMA inbound the low half is always chosen
   always_comb begin
      a_slave_low_r10: assert (dma_sink || !take_high);
   end

endmodule

// File: rtl/bls_capture.sv
module bls_capture #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout,
   output logic              valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= load;
         if (load) dout <= din;
      end
   end

   // R11: one pulse per load, none otherwise
   p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> valid);

   p_valid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> !valid);

   p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(dout));

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
   import bls_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter bit HAS_SWAP = 1'b1,
   parameter int EN_BIT   = 0,
   parameter int SEL_BIT  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dma_act,
   input  logic                 dma_dir,
   input  logic                 addr_a0,
   input  logic                 src_stb,
   input  logic                 snk_stb,
   input  logic                 cfg_sel,
   input  logic [BYTE_W-1:0]    out_byte,
   input  logic [2*BYTE_W-1:0]  bus_in,
   output logic [2*BYTE_W-1:0]  bus_out,
   output logic                 bus_oe,
   output logic [BYTE_W-1:0]    in_byte,
   output logic                 in_valid
);

   localparam int BUS_W = 2 * BYTE_W;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must hold both configuration bits");
      end
   endgenerate

   bls_phase_e          phase;
   bls_cfg_t            cfg;
   logic [BYTE_W-1:0]   cfg_rd;
   logic [BYTE_W-1:0]   src_byte;
   logic [BYTE_W-1:0]   lane_byte;
   logic                take_high;
   logic                cfg_wr;
   logic                data_load;
   logic                dma_sink;

   always_comb phase = bls_decode(dma_act, dma_dir, src_stb, snk_stb);

   assign dma_sink  = (phase == PH_DMA_SINK);
   assign cfg_wr    = (phase == PH_SLV_SINK) && cfg_sel;
   assign data_load = ((phase == PH_SLV_SINK) && !cfg_sel) || dma_sink;

   bls_cfg_reg #(
      .BYTE_W (BYTE_W),
      .EN_BIT (EN_BIT),
      .SEL_BIT(SEL_BIT)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr),
      .wr_byte(bus_in[BYTE_W-1:0]),
      .cfg    (cfg),
      .rd_byte(cfg_rd)
   );

   bls_lane_sel #(
      .BYTE_W  (BYTE_W),
      .HAS_SWAP(HAS_SWAP)
   ) u_lane (
      .bus_word (bus_in),
      .dma_sink (dma_sink),
      .swap_en  (cfg.swap_en),
      .swap_sel (cfg.swap_sel),
      .a0       (addr_a0),
      .take_high(take_high),
      .lane_byte(lane_byte)
   );

   bls_capture #(
      .BYTE_W(BYTE_W)
   ) u_cap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (data_load),
      .din  (lane_byte),
      .dout (in_byte),
      .valid(in_valid)
   );

   // configuration readback only in slave mode
   assign src_byte = (cfg_sel && !dma_act) ? cfg_rd : out_byte;
   assign bus_oe   = (phase == PH_SOURCE);

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         assign bus_out[h*BYTE_W +: BYTE_W] = bus_oe ? src_byte : '0;
      end
   endgenerate

   // R2 R4: both halves carry the same byte while driving
   always_comb begin
      a_replicate_r4: assert (!bus_oe ||
         (bus_out[BUS_W-1:BYTE_W] == bus_out[BYTE_W-1:0]));
   end

   // R9: no drive toward a device-bound DMA transfer
   p_no_drive_dma_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_act && !dma_dir) |-> !bus_oe);

   // R5: swap disabled keeps the low half for DMA inbound
   p_dma_noswap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_sink && !cfg.swap_en) |=> in_byte == $past(bus_in[BYTE_W-1:0]));

   // R3 R10: slave data writes use the low half
   p_slave_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_SLV_SINK) && !cfg_sel) |=> in_byte == $past(bus_in[BYTE_W-1:0]));

endmodule

// File: tb/tb_byte_lane_steer.sv
module tb_byte_lane_steer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dma_act = 0, dma_dir = 0, addr_a0 = 0;
   logic        src_stb = 0, snk_stb = 0, cfg_sel = 0;
   logic [7:0]  out_byte = '0;
   logic [15:0] bus_in = '0;
   logic [15:0] bus_out;
   logic        bus_oe;
   logic [7:0]  in_byte;
   logic        in_valid;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_lane_steer dut (
      .clk(clk), .rst_n(rst_n), .dma_act(dma_act), .dma_dir(dma_dir),
      .addr_a0(addr_a0), .src_stb(src_stb), .snk_stb(snk_stb),
      .cfg_sel(cfg_sel), .out_byte(out_byte), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .in_byte(in_byte),
      .in_valid(in_valid)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      dma_act = 0; dma_dir = 0; addr_a0 = 0;
      src_stb = 0; snk_stb = 0; cfg_sel = 0;
      bus_in = '0; out_byte = '0;
   endtask

   // one inbound transfer; returns captured byte and valid after the edge
   task automatic sink(input bit dma, input bit cfg, input bit a0,
                       input logic [15:0] word,
                       output logic [7:0] got, output logic vld);
      @(negedge clk);
      idle_inputs();
      dma_act = dma; dma_dir = 0; cfg_sel = cfg; addr_a0 = a0;
      snk_stb = 1; bus_in = word;
      @(posedge clk); #1;
      got = in_byte; vld = in_valid;
      @(negedge clk);
      idle_inputs();
   endtask

   // one outbound transfer sampled mid-cycle
   task automatic source(input bit dma, input bit cfg, input logic [7:0] b,
                         output logic [15:0] word, output logic oe);
      @(negedge clk);
      idle_inputs();
      dma_act = dma; dma_dir = dma; cfg_sel = cfg; src_stb = 1; out_byte = b;
      #1;
      word = bus_out; oe = bus_oe;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      logic [15:0] w; logic oe;
      #1;
      chk(bus_oe == 0, "R1 oe", {15'b0, bus_oe}, 16'h0);
      chk(bus_out == 0, "R1 bus_out", bus_out, 16'h0);
      chk(in_valid == 0, "R1 valid", {15'b0, in_valid}, 16'h0);
      source(0, 1, 8'hFF, w, oe);
      chk(w == 16'h0000, "R1 R8 cfg reset readback", w, 16'h0000);
   endtask

   task automatic t_slave_read();
      logic [15:0] w; logic oe;
      source(0, 0, 8'hA5, w, oe);
      chk(oe == 1, "R2 oe", {15'b0, oe}, 16'h1);
      chk(w == 16'hA5A5, "R2 replicate", w, 16'hA5A5);
   endtask

   task automatic t_dma_out();
      logic [15:0] w; logic oe;
      source(1, 0, 8'h5A, w, oe);
      chk(oe == 1, "R4 oe", {15'b0, oe}, 16'h1);
      chk(w == 16'h5A5A, "R4 replicate", w, 16'h5A5A);
   endtask

   task automatic t_no_drive();
      @(negedge clk);
      idle_inputs(); out_byte = 8'h77; #1;
      chk(bus_oe == 0 && bus_out == 0, "R9 idle", bus_out, 16'h0);
      dma_act = 1; dma_dir = 0; src_stb = 1; #1;
      chk(bus_oe == 0 && bus_out == 0, "R9 dma inbound src", bus_out, 16'h0);
      src_stb = 0; snk_stb = 0; #1;
      chk(bus_oe == 0, "R9 dma active idle", {15'b0, bus_oe}, 16'h0);
      @(negedge clk); idle_inputs();
   endtask

   task automatic t_slave_write();
      logic [7:0] g; logic v;
      sink(0, 0, 1, 16'h3C7E, g, v);
      chk(v == 1, "R3 valid", {15'b0, v}, 16'h1);
      chk(g == 8'h7E, "R3 low half", {8'h0, g}, 16'h7E);
      #1;
      @(posedge clk); #1;
      chk(in_valid == 0, "R11 single pulse", {15'b0, in_valid}, 16'h0);
   endtask

   task automatic t_dma_noswap();
      logic [7:0] g; logic v;
      sink(1, 0, 0, 16'hC318, g, v);
      chk(g == 8'h18 && v, "R5 a0=0", {8'h0, g}, 16'h18);
      sink(1, 0, 1, 16'h9124, g, v);
      chk(g == 8'h24 && v, "R5 a0=1", {8'h0, g}, 16'h24);
   endtask

   task automatic cfg_write(input logic [7:0] val);
      logic [7:0] g; logic v;
      // configuration write, immediately followed by use in next cycle
      @(negedge clk);
      idle_inputs();
      cfg_sel = 1; snk_stb = 1; bus_in = {8'hFC, val};
      @(posedge clk); #1;
      chk(in_valid == 0, "R11 no pulse on cfg write", {15'b0, in_valid}, 16'h0);
      g = 0; v = 0;
   endtask

   task automatic t_swap_sel1();
      logic [7:0] g; logic v; logic [15:0] w; logic oe;
      cfg_write(8'h03);
      sink(1, 0, 0, 16'hB14D, g, v);
      chk(g == 8'h4D, "R6 R8 a0=0 low next cycle", {8'h0, g}, 16'h4D);
      sink(1, 0, 1, 16'hB14D, g, v);
      chk(g == 8'hB1, "R6 a0=1 high", {8'h0, g}, 16'hB1);
      source(0, 1, 8'h00, w, oe);
      chk(w == 16'h0303, "R8 readback", w, 16'h0303);
      sink(0, 0, 1, 16'hE29C, g, v);
      chk(g == 8'h9C && v, "R10 slave ignores swap a0=1", {8'h0, g}, 16'h9C);
      sink(0, 0, 0, 16'hE29C, g, v);
      chk(g == 8'h9C, "R10 slave ignores swap a0=0", {8'h0, g}, 16'h9C);
   endtask

   task automatic t_swap_sel0();
      logic [7:0] g; logic v;
      cfg_write(8'h01);
      sink(1, 0, 0, 16'h6AD3, g, v);
      chk(g == 8'h6A, "R7 a0=0 high", {8'h0, g}, 16'h6A);
      sink(1, 0, 1, 16'h6AD3, g, v);
      chk(g == 8'hD3, "R7 a0=1 low", {8'h0, g}, 16'hD3);
      cfg_write(8'h00);
      sink(1, 0, 0, 16'h8F42, g, v);
      chk(g == 8'h42, "R5 R8 swap cleared", {8'h0, g}, 16'h42);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk); rst_n = 1;
      t_reset();
      t_slave_read();
      t_dma_out();
      t_no_drive();
      t_slave_write();
      t_dma_noswap();
      t_swap_sel1();
      t_swap_sel0();
      repeat (2) @(posedge clk);
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule